// File: doc/BRIEF.md
# Oversampled DPLL NRZI Bit Recovery

This block takes a single demodulated line that carries NRZI-coded data at a fixed symbol rate and recovers the data bits. It does not sample on every clock. It samples on a programmable number of base-time units, which arrive as a one-cycle enable pulse. Most samples only feed the edge history. Every second or third sample is a decision sample: it makes the bit decision, and it may stretch or shrink the next sample interval by one unit to keep the decision point centred in the symbol.

Phase correction uses no accumulator. A small window of recent edge flags is compared with fixed patterns, and the result sets only the interval that follows the decision sample. The decoded bits are packed into words by a marker bit that moves through a shift register, so no bit counter is needed. Each full word is presented for one cycle with a valid strobe. The output has no backpressure.

The mode input selects between three samples per bit (nominal interval 4 units) and two samples per bit (nominal interval 6 units). It may change only while reset is asserted. A signed correction output pulses so that phase-locked-loop activity can be counted.

Top module: `nrzi_dpll_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `word_valid` is 0, `pll_adj` is 0 and `word_data` is 0.
- R2: With `mode_duo`=0, every sample interval that is not corrected is 4 units. The first sample falls on the 4th `unit_en` pulse after reset, and that sample is a decision sample. Samples then cycle decision, intermediate, intermediate.
- R3: With `mode_duo`=0, each sample shifts an edge flag (sampled level differs from the previous sample; the previous level is 0 after reset) into a history, with the newest flag in bit 0. At a decision sample, history[2:0]=001 makes the next interval 5 units and `pll_adj` +1. History 100 makes it 3 units and `pll_adj` -1. Any other value keeps it at 4.
- R4: With `mode_duo`=1, the nominal interval is 6 units and samples alternate decision, intermediate. The first sample, on the 6th `unit_en` pulse, is a decision sample.
- R5: With `mode_duo`=1, at a decision sample, history[1:0]=01 makes the next interval 7 units and `pll_adj` +1. History 10 makes it 5 units and `pll_adj` -1.
- R6: An intermediate sample always schedules the nominal interval of the current mode.
- R7: The decoded bit is 1 when the decision sample equals the previous decision sample and 0 when it differs. The previous decision level is 0 after reset.
- R8: Decoded bits fill a 16-bit word, least significant bit first in time. After 16 bits, `word_data` holds the word and `word_valid` is high for exactly one cycle, starting in the cycle after the 16th decision sample. Packing then restarts empty.
- R9: Time advances only on cycles with `unit_en` high. Gaps in `unit_en` leave the recovered words unchanged.
- R10: `pll_adj` is nonzero only in the cycle after a decision sample and lasts one cycle. Its coding is 2'b01 = +1 (late) and 2'b11 = -1 (early).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | One-cycle pulse marking one base-time unit |
| mode_duo | input | 1 | 0: three samples per bit; 1: two samples per bit (change only in reset) |
| line_in | input | 1 | Demodulated NRZI line level |
| word_data | output | 16 | Last completed word, first bit in bit 0 |
| word_valid | output | 1 | One-cycle strobe for a new word |
| pll_adj | output | 2 | Signed phase-correction pulse: +1 late, -1 early |

## Verification
The bench builds the block with its default 16-bit word and the nominal intervals 4 and 6. It drives symbol periods of 11, 12 and 13 units, so that a locked stream, a slow stream and a fast stream all occur. With these values a 12-unit symbol aligned at offset 2 is locked from the first sample, so the recovered words can be compared directly with the NRZI source data. The same data is also sent with dense, alternating and pseudo-random `unit_en` gaps. In the two-sample mode, a time-based model of the sampling rules predicts each correction pulse and word.

// File: rtl/nrzi_dpll_pkg.sv
package nrzi_dpll_pkg;

  // Phase verdict, coded so the raw bits read as a signed step.
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'b00,
    ADJ_LATE  = 2'b01,
    ADJ_EARLY = 2'b11
  } adj_e;

  // Edge window seen at a decision sample: {older, previous, newest}.
  localparam int WIN_W = 3;

  // Pattern match of the edge window. duo selects the two-sample rule.
  function automatic adj_e judge_window(input logic duo, input logic [WIN_W-1:0] win);
    adj_e v;
    v = ADJ_NONE;
    if (!duo) begin
      if (win == 3'b001)      v = ADJ_LATE;
      else if (win == 3'b100) v = ADJ_EARLY;
    end else begin
      if (win[1:0] == 2'b01)      v = ADJ_LATE;
      else if (win[1:0] == 2'b10) v = ADJ_EARLY;
    end
    return v;
  endfunction

  // Interval that follows a sample, given the nominal length and verdict.
  function automatic int step_interval(input int nominal, input adj_e v);
    int r;
    case (v)
      ADJ_LATE:  r = nominal + 1;
      ADJ_EARLY: r = nominal - 1;
      default:   r = nominal;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nrzi_dpll_tick.sv
// Counts base-time units and fires a sample tick when the interval has elapsed.
module nrzi_dpll_tick #(
  parameter int IVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_en,
  input  logic [IVL_W-1:0] nom_ivl,
  input  logic [IVL_W-1:0] next_ivl,
  output logic             sample_tick,
  output logic [IVL_W-1:0] cur_ivl
);

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] ivl_q;

  assign sample_tick = unit_en && (cnt_q == ivl_q - IVL_W'(1));
  assign cur_ivl     = ivl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ivl_q <= nom_ivl;
    end else if (unit_en) begin
      if (sample_tick) begin
        cnt_q <= '0;
        ivl_q <= next_ivl;
      end else begin
        cnt_q <= cnt_q + IVL_W'(1);
      end
    end
  end

endmodule

// File: rtl/nrzi_dpll_phase.sv
// Edge history, sample-phase sequencing and interval selection.
module nrzi_dpll_phase
  import nrzi_dpll_pkg::*;
#(
  parameter int IVL_W   = 3,
  parameter int NOM_TRI = 4,
  parameter int NOM_DUO = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_duo,
  input  logic             sample_tick,
  input  logic             line_in,
  output logic             decide_tick,
  output logic [IVL_W-1:0] nom_ivl,
  output logic [IVL_W-1:0] next_ivl,
  output adj_e             adj_q
);

  logic [1:0]       phase_q;
  logic             last_q;
  logic [1:0]       hist_q;
  logic             edge_flag;
  logic [WIN_W-1:0] window;
  logic [1:0]       wrap;
  adj_e             verdict;

  assign edge_flag   = line_in ^ last_q;
  assign window      = {hist_q, edge_flag};
  assign decide_tick = sample_tick && (phase_q == 2'd0);
  assign wrap        = mode_duo ? 2'd1 : 2'd2;
  assign nom_ivl     = mode_duo ? IVL_W'(NOM_DUO) : IVL_W'(NOM_TRI);
  assign verdict     = decide_tick ? judge_window(mode_duo, window) : ADJ_NONE;

  always_comb begin
    next_ivl = IVL_W'(step_interval(mode_duo ? NOM_DUO : NOM_TRI, verdict));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      last_q  <= 1'b0;
      hist_q  <= 2'b00;
      adj_q   <= ADJ_NONE;
    end else begin
      adj_q <= verdict;
      if (sample_tick) begin
        last_q  <= line_in;
        hist_q  <= window[1:0];
        phase_q <= (phase_q >= wrap) ? 2'd0 : phase_q + 2'd1;
      end
    end
  end

endmodule

// File: rtl/nrzi_dpll_pack.sv
// NRZI decode at decision samples and marker-driven word assembly.
module nrzi_dpll_pack #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decide_tick,
  input  logic              line_in,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);

  localparam logic [WORD_W-1:0] EMPTY = {1'b1, {(WORD_W-1){1'b0}}};

  // fill_q holds the upper WORD_W bits of the assembly register; the marker
  // reaching bit 0 of fill_q means the incoming bit completes a word.
  logic [WORD_W-1:0] fill_q;
  logic              last_rx_q;
  logic              bit_val;
  logic [WORD_W-1:0] shifted;

  assign bit_val = (line_in == last_rx_q);
  assign shifted = {bit_val, fill_q[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q     <= EMPTY;
      last_rx_q  <= 1'b0;
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (decide_tick) begin
        last_rx_q <= line_in;
        if (fill_q[0]) begin
          word_data  <= shifted;
          word_valid <= 1'b1;
          fill_q     <= EMPTY;
        end else begin
          fill_q <= shifted;
        end
      end
    end
  end

endmodule

// File: rtl/nrzi_dpll_rx.sv
// Top: oversampled DPLL recovery of NRZI data into words.
module nrzi_dpll_rx
  import nrzi_dpll_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int NOM_TRI = 4,
  parameter int NOM_DUO = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              mode_duo,
  input  logic              line_in,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic signed [1:0] pll_adj
);

  localparam int NOM_MAX = (NOM_DUO > NOM_TRI) ? NOM_DUO : NOM_TRI;
  localparam int IVL_W   = $clog2(NOM_MAX + 2);

  logic             sample_tick;
  logic             decide_tick;
  logic [IVL_W-1:0] nom_ivl;
  logic [IVL_W-1:0] next_ivl;
  logic [IVL_W-1:0] cur_ivl;
  adj_e             adj_q;

  nrzi_dpll_tick #(.IVL_W(IVL_W)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_en     (unit_en),
    .nom_ivl     (nom_ivl),
    .next_ivl    (next_ivl),
    .sample_tick (sample_tick),
    .cur_ivl     (cur_ivl)
  );

  nrzi_dpll_phase #(.IVL_W(IVL_W), .NOM_TRI(NOM_TRI), .NOM_DUO(NOM_DUO)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_duo    (mode_duo),
    .sample_tick (sample_tick),
    .line_in     (line_in),
    .decide_tick (decide_tick),
    .nom_ivl     (nom_ivl),
    .next_ivl    (next_ivl),
    .adj_q       (adj_q)
  );

  nrzi_dpll_pack #(.WORD_W(WORD_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .decide_tick (decide_tick),
    .line_in     (line_in),
    .word_data   (word_data),
    .word_valid  (word_valid)
  );

  assign pll_adj = adj_q;

endmodule

// File: rtl/nrzi_dpll_rx_chk.sv
// Property checker bound to the top module.
module nrzi_dpll_rx_chk #(
  parameter int IVL_W   = 3,
  parameter int NOM_TRI = 4,
  parameter int NOM_DUO = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unit_en,
  input logic              mode_duo,
  input logic              sample_tick,
  input logic              decide_tick,
  input logic [IVL_W-1:0]  cur_ivl,
  input logic              word_valid,
  input logic signed [1:0] pll_adj
);

  localparam logic [IVL_W-1:0] TRI_N = IVL_W'(NOM_TRI);
  localparam logic [IVL_W-1:0] DUO_N = IVL_W'(NOM_DUO);

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_valid_after_decide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(decide_tick));

  p_adj_after_decide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_adj != 2'sd0) |-> $past(decide_tick));

  p_adj_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_adj != 2'sd0) |=> (pll_adj == 2'sd0));

  p_tri_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_duo |-> (cur_ivl >= TRI_N - IVL_W'(1) && cur_ivl <= TRI_N + IVL_W'(1)));

  p_duo_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_duo |-> (cur_ivl >= DUO_N - IVL_W'(1) && cur_ivl <= DUO_N + IVL_W'(1)));

  p_interm_nominal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !decide_tick) |=> (cur_ivl == (mode_duo ? DUO_N : TRI_N)));

  p_word_needs_unit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(unit_en));

  p_mode_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_duo));

endmodule

bind nrzi_dpll_rx nrzi_dpll_rx_chk #(
  .IVL_W(IVL_W), .NOM_TRI(NOM_TRI), .NOM_DUO(NOM_DUO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .unit_en     (unit_en),
  .mode_duo    (mode_duo),
  .sample_tick (sample_tick),
  .decide_tick (decide_tick),
  .cur_ivl     (cur_ivl),
  .word_valid  (word_valid),
  .pll_adj     (pll_adj)
);

// File: tb/nrzi_dpll_rx_tb.sv
module nrzi_dpll_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 96;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unit_en = 1'b0;
  logic mode_duo = 1'b0;
  logic line_in = 1'b0;
  logic [15:0] word_data;
  logic word_valid;
  logic signed [1:0] pll_adj;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrzi_dpll_rx u_dut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .mode_duo(mode_duo),
    .line_in(line_in), .word_data(word_data), .word_valid(word_valid),
    .pll_adj(pll_adj)
  );

  // Source stream: dbits are the data, lv the NRZI line levels per symbol.
  logic dbits [NB];
  logic lv [NB];
  int per, off, en_mode;
  logic [15:0] rs;

  // Time-based expectation: units elapsed and the unit of the next sample.
  int mu, mnext, mph;
  logic mlast, mrx;
  logic [2:0] mh;
  logic [16:0] masm;
  logic ev;
  logic [15:0] ew;
  int eadj;
  int lates, earlies, ngot, cyc;
  logic [15:0] got [8];

  function automatic logic [15:0] lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic level_at(input int n);
    int idx;
    idx = (n + off) / per;
    if (idx >= NB) idx = NB - 1;
    return lv[idx];
  endfunction

  function automatic int nominal();
    return mode_duo ? 6 : 4;
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_data(input logic [15:0] seed, input bit ones);
    rs = seed;
    dbits[0] = 1'b1;
    lv[0] = 1'b0;
    for (int b = 1; b < NB; b++) begin
      rs = lfsr(rs);
      dbits[b] = ones ? 1'b1 : rs[0];
      lv[b] = dbits[b] ? lv[b-1] : ~lv[b-1];
    end
  endtask

  task automatic model_reset();
    mu = 0; mnext = nominal(); mph = 0;
    mlast = 1'b0; mrx = 1'b0; mh = 3'b000; masm = 17'h10000;
    ev = 1'b0; ew = 16'h0; eadj = 0;
    lates = 0; earlies = 0; ngot = 0;
  endtask

  task automatic model_step(input logic en, input logic lvl);
    int gap;
    logic b;
    ev = 1'b0;
    eadj = 0;
    if (en) begin
      mu++;
      if (mu == mnext) begin
        mh = {mh[1:0], lvl != mlast};
        mlast = lvl;
        gap = nominal();
        if (mph == 0) begin
          if (!mode_duo) begin
            if (mh == 3'b001) eadj = 1;
            else if (mh == 3'b100) eadj = -1;
          end else begin
            if (mh[1:0] == 2'b01) eadj = 1;
            else if (mh[1:0] == 2'b10) eadj = -1;
          end
          gap = nominal() + eadj;
          b = (lvl == mrx);
          mrx = lvl;
          masm = {b, masm[16:1]};
          if (masm[0]) begin
            ev = 1'b1;
            ew = masm[16:1];
            masm = 17'h10000;
          end
        end
        mph = (mph + 1) % (mode_duo ? 2 : 3);
        mnext = mu + gap;
      end
    end
  endtask

  task automatic compare(input string req);
    if (ev || word_valid) begin
      check({req, " R8 valid"}, int'(word_valid), int'(ev));
      if (ev) check({req, " R7 word"}, int'(word_data), int'(ew));
    end
    if (eadj != 0 || pll_adj != 2'sd0)
      check({req, " R10 adj"}, int'(pll_adj), eadj);
    if (word_valid && ngot < 8) begin
      got[ngot] = word_data;
      ngot++;
    end
    if (pll_adj == 2'sd1) lates++;
    if (pll_adj == -2'sd1) earlies++;
  endtask

  task automatic do_reset(input logic duo);
    rst_n = 1'b0;
    unit_en = 1'b0;
    line_in = 1'b0;
    @(negedge clk);
    mode_duo = duo;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(word_valid), 0);
    check("R1 adj in reset", int'(pll_adj), 0);
    check("R1 word in reset", int'(word_data), 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic run(input string req, input int ncyc);
    logic en;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      compare(req);
      case (en_mode)
        0: en = 1'b1;
        1: en = c[0];
        default: begin rs = lfsr(rs); en = rs[0] | rs[3]; end
      endcase
      unit_en = en;
      line_in = level_at(mu + 1);
      model_step(en, line_in);
    end
    @(negedge clk);
    compare(req);
    unit_en = 1'b0;
  endtask

  task automatic check_words(input string req);
    logic [15:0] w;
    check({req, " word count"}, int'(ngot >= 4), 1);
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 16; i++) w[i] = dbits[16*k + i];
      check(req, int'(got[k]), int'(w));
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d cycles", WDOG, 0);
    report();
    $finish;
  end

  initial begin
    per = 12; off = 2; en_mode = 0;
    fill_data(16'hACE1, 1'b0);

    // R1 first cycle after reset
    do_reset(1'b0);
    @(negedge clk);
    check("R1 valid after release", int'(word_valid), 0);
    check("R1 adj after release", int'(pll_adj), 0);
    do_reset(1'b0);

    // R2 R7 R8: locked 12-unit symbols, data checked against the source
    run("R2 locked tri", (NB - 6) * per);
    check_words("R8 tri words");
    check("R2 no correction when locked", lates + earlies, 0);

    // R9: gaps in unit_en leave the words unchanged
    en_mode = 1;
    do_reset(1'b0);
    run("R9 alternate enable", 2 * (NB - 6) * per);
    check_words("R9 alternate words");
    en_mode = 2; rs = 16'h1234;
    do_reset(1'b0);
    run("R9 random enable", 2 * (NB - 6) * per);
    check_words("R9 random words");
    check("R9 no correction with gaps", lates + earlies, 0);

    // R3: slow and fast symbol streams force corrections
    en_mode = 0; per = 13; off = 2;
    fill_data(16'h5A5A, 1'b0);
    do_reset(1'b0);
    run("R3 slow tri", (NB - 6) * 12);
    check("R3 late corrections seen", int'(lates > 0), 1);
    per = 11;
    do_reset(1'b0);
    run("R3 fast tri", (NB - 6) * 10);
    check("R3 early corrections seen", int'(earlies > 0), 1);

    // R5 R6: two-sample mode on edged data
    per = 12; off = 2;
    fill_data(16'hBEEF, 1'b0);
    do_reset(1'b1);
    run("R5 duo data", (NB - 6) * per);
    check("R5 corrections seen", int'(lates + earlies > 0), 1);

    // R4 R7: two-sample mode on a constant line gives all-ones words
    fill_data(16'h0001, 1'b1);
    do_reset(1'b1);
    run("R4 duo constant", 40 * per);
    check("R4 words seen", int'(ngot >= 2), 1);
    check("R7 duo word ones", int'(got[0]), 16'hFFFF);
    check("R4 no correction on constant", lates + earlies, 0);

    report();
    $finish;
  end

endmodule